// File: doc/BRIEF.md
# Reference-Ratio Frequency Lock Detector

This block decides whether a recovered bit clock runs at the frequency set by a reference clock and a programmable power-of-two ratio. It never looks at the incoming data stream. The only evidence it uses is the two clocks' edge rates. Both clocks reach the block as single-cycle edge strobes, `ref_tick_i` and `vco_tick_i`, which upstream synchronizers produce in the block's own clock domain.

An 8-bit control word is loaded through a parallel write port and holds three fields:
- a reference band field in bits [7:6];
- a rate-ratio field in bits [5:2];
- a start bit in bit 0.

The target is met when the recovered rate divided by 2^ratio equals the reference rate divided by 2^band. For example, a 125 MHz reference with band 11 and ratio 0011 gives a 125 Mb/s target. Band 11 is the 100 to 200 MHz reference band.

Checking begins only when a write moves the start bit from 0 to 1. The block then counts both strobes over back-to-back windows of `WIN_CYC` clock cycles. It shifts the reference count left by the ratio and right by the band, and compares the result with the recovered count. The lock output asserts after `LOCK_WINS` consecutive windows within tolerance and drops after one window outside it.

Top module: `refclk_lock_det`

## Requirements
- R1: After reset `lock_o` is 0 and `ctrl_o` is 0.
- R2: A write with `wr_en_i` high loads `wr_data_i` into the control word, and `ctrl_o` shows it on the next cycle. The band field is bits [7:6], the ratio field is bits [5:2] and the start bit is bit 0.
- R3: Checking is armed only by a write that moves bit 0 from 0 to 1. Rewriting the word with bit 0 already 1 and unchanged fields neither arms nor disturbs checking.
- R4: A window is good when |vco_count - ((ref_count << ratio) >> band)| <= `TOL`. The counts are the strobes seen during `WIN_CYC` cycles. With band 11 and ratio 0011, equal strobe rates are good.
- R5: `lock_o` rises only after `LOCK_WINS` (2) consecutive good windows. It is still 0 after the first good window.
- R6: One window that is not good clears `lock_o` on the cycle after the window's result.
- R7: A write that changes bits [7:2] clears `lock_o` on the next cycle and disarms checking until the next 0-to-1 edge of bit 0.
- R8: A write with bit 0 equal to 0 clears `lock_o` on the next cycle and disarms checking.
- R9: The ratio and band fields scale the target. Ratio 0100 with band 11 expects twice the reference rate, ratio 0010 with band 11 expects half, and band 00 with ratio 0000 expects equal rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| ref_tick_i | input | 1 | One pulse per reference clock edge |
| vco_tick_i | input | 1 | One pulse per recovered clock edge |
| ctrl_o | output | 8 | Current control word |
| lock_o | output | 1 | Frequency lock indication |

## Verification
Suppose the arm flag is wrong: set by a plain rewrite, or left set after a field change. Then `lock_o` rises about two windows later under matching strobes, where it should stay low. That is visible within 2*`WIN_CYC` cycles.

A wrong scaling shift or tolerance compare makes matching ratio settings never lock. It can also make near-miss settings lock, again within two windows.

A streak counter that is off by one shows up as lock after the first good window or after the third. Watching `lock_o` at 1.5 and 2.5 windows after arming separates these cases.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  localparam int CTRL_W  = 8;
  localparam int BAND_W  = 2;
  localparam int RATIO_W = 4;
  localparam int MAX_SHL = (1 << RATIO_W) - 1;

  typedef struct packed {
    logic [BAND_W-1:0]  band;   // [7:6]
    logic [RATIO_W-1:0] ratio;  // [5:2]
    logic               rsvd;   // [1]
    logic               start;  // [0]
  } ctrl_t;
endpackage

// File: rtl/lkd_ctrl.sv
module lkd_ctrl
  import lkd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic              arm_o,
  output logic              restart_o,
  output logic              clr_o
);
  ctrl_t ctrl_q, wr_w;
  logic  arm_q, rise_w, fld_chg_w;

  assign wr_w      = ctrl_t'(wr_data_i);
  assign rise_w    = wr_en_i && wr_w.start && !ctrl_q.start;
  assign fld_chg_w = wr_en_i && ({wr_w.band, wr_w.ratio} != {ctrl_q.band, ctrl_q.ratio});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      arm_q  <= 1'b0;
    end else if (wr_en_i) begin
      ctrl_q <= wr_w;
      if (rise_w)                      arm_q <= 1'b1;
      else if (fld_chg_w || !wr_w.start) arm_q <= 1'b0;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign arm_o     = arm_q;
  assign restart_o = rise_w;
  // any write that re-arms or disarms drops lock at once
  assign clr_o     = rise_w || fld_chg_w || (wr_en_i && !wr_w.start);
endmodule

// File: rtl/lkd_window.sv
module lkd_window #(
  parameter int WIN_CYC = 256,
  localparam int CNT_W  = $clog2(WIN_CYC + 1),
  localparam int TIM_W  = $clog2(WIN_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             restart_i,
  input  logic             ref_tick_i,
  input  logic             vco_tick_i,
  output logic             vld_o,
  output logic [CNT_W-1:0] ref_cnt_o,
  output logic [CNT_W-1:0] vco_cnt_o
);
  logic [TIM_W-1:0] tim_q;
  logic [CNT_W-1:0] ref_q, vco_q, ref_nxt, vco_nxt;
  logic             last_w;

  assign last_w  = (tim_q == TIM_W'(WIN_CYC - 1));
  assign ref_nxt = ref_q + CNT_W'(ref_tick_i);
  assign vco_nxt = vco_q + CNT_W'(vco_tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q <= '0;
      ref_q <= '0;
      vco_q <= '0;
    end else if (restart_i || !arm_i || last_w) begin
      tim_q <= '0;
      ref_q <= '0;
      vco_q <= '0;
    end else begin
      tim_q <= tim_q + TIM_W'(1);
      ref_q <= ref_nxt;
      vco_q <= vco_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o     <= 1'b0;
      ref_cnt_o <= '0;
      vco_cnt_o <= '0;
    end else begin
      vld_o <= arm_i && last_w && !restart_i;
      if (arm_i && last_w) begin
        ref_cnt_o <= ref_nxt;
        vco_cnt_o <= vco_nxt;
      end
    end
  end
endmodule

// File: rtl/lkd_compare.sv
module lkd_compare
  import lkd_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int TOL   = 2,
  localparam int SC_W = CNT_W + MAX_SHL
) (
  input  logic [CNT_W-1:0]   ref_cnt_i,
  input  logic [CNT_W-1:0]   vco_cnt_i,
  input  logic [BAND_W-1:0]  band_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               good_o
);
  logic [SC_W-1:0] scaled_w, vco_w, diff_w;

  assign scaled_w = (SC_W'(ref_cnt_i) << ratio_i) >> band_i;
  assign vco_w    = SC_W'(vco_cnt_i);
  assign diff_w   = (vco_w > scaled_w) ? (vco_w - scaled_w) : (scaled_w - vco_w);
  assign good_o   = (diff_w <= SC_W'(TOL));
endmodule

// File: rtl/lkd_qualify.sv
module lkd_qualify #(
  parameter int LOCK_WINS = 2,
  localparam int STK_W    = $clog2(LOCK_WINS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic good_i,
  output logic lock_o
);
  logic [STK_W-1:0] stk_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stk_q  <= '0;
      lock_q <= 1'b0;
    end else if (clr_i) begin
      stk_q  <= '0;
      lock_q <= 1'b0;
    end else if (vld_i) begin
      if (good_i) begin
        if (stk_q != STK_W'(LOCK_WINS)) stk_q <= stk_q + STK_W'(1);
        if (stk_q >= STK_W'(LOCK_WINS - 1)) lock_q <= 1'b1;
      end else begin
        stk_q  <= '0;
        lock_q <= 1'b0;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/refclk_lock_det.sv
module refclk_lock_det
  import lkd_pkg::*;
#(
  parameter int WIN_CYC   = 256,
  parameter int TOL       = 2,
  parameter int LOCK_WINS = 2,
  localparam int CNT_W    = $clog2(WIN_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              ref_tick_i,
  input  logic              vco_tick_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              lock_o
);
  ctrl_t            ctrl_w;
  logic             arm_w, restart_w, clr_w;
  logic             win_vld, win_good;
  logic [CNT_W-1:0] ref_cnt_w, vco_cnt_w;

  lkd_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .ctrl_o(ctrl_w), .arm_o(arm_w), .restart_o(restart_w), .clr_o(clr_w)
  );

  lkd_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i, .rst_ni, .arm_i(arm_w), .restart_i(restart_w),
    .ref_tick_i, .vco_tick_i,
    .vld_o(win_vld), .ref_cnt_o(ref_cnt_w), .vco_cnt_o(vco_cnt_w)
  );

  lkd_compare #(.CNT_W(CNT_W), .TOL(TOL)) u_cmp (
    .ref_cnt_i(ref_cnt_w), .vco_cnt_i(vco_cnt_w),
    .band_i(ctrl_w.band), .ratio_i(ctrl_w.ratio), .good_o(win_good)
  );

  lkd_qualify #(.LOCK_WINS(LOCK_WINS)) u_qual (
    .clk_i, .rst_ni, .clr_i(clr_w), .vld_i(win_vld), .good_i(win_good),
    .lock_o
  );

  assign ctrl_o = ctrl_w;
endmodule

// File: rtl/refclk_lock_det_chk.sv
module refclk_lock_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] ctrl_o,
  input logic       lock_o,
  input logic       win_vld_i,
  input logic       win_good_i
);
  // R2
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ctrl_o == $past(wr_data_i)));

  // R7
  fld_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i[7:2] != ctrl_o[7:2])) |=> !lock_o);

  // R8
  stop_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[0]) |=> !lock_o);

  // R6
  bad_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_vld_i && !win_good_i) |=> !lock_o);

  // R5
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(win_vld_i && win_good_i) && ctrl_o[0]));
endmodule

bind refclk_lock_det refclk_lock_det_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .ctrl_o(ctrl_o), .lock_o(lock_o), .win_vld_i(win_vld), .win_good_i(win_good)
);

// File: tb/refclk_lock_det_tb.sv
module refclk_lock_det_tb;
  localparam int WIN = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ref_tick = 1'b0, vco_tick = 1'b0;
  logic [7:0] ctrl;
  logic       lock;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ref_per = 4, vco_per = 4, skip = 0;
  int ph = 0, vslot = 0;

  always #10 clk = ~clk;

  refclk_lock_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ref_tick_i(ref_tick), .vco_tick_i(vco_tick), .ctrl_o(ctrl), .lock_o(lock)
  );

  // strobe generators; vco skips 'skip' of every 64 slots
  initial forever begin
    @(negedge clk);
    ph++;
    ref_tick = (ph % ref_per == 0);
    if (ph % vco_per == 0) begin
      vco_tick = ((vslot % 64) >= skip);
      vslot++;
    end else vco_tick = 1'b0;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // band 11, ratio 0011 -> 8'hCD when started
  task automatic t_reset;
    check("R1 lock", {7'd0, lock}, 8'd0);
    check("R1 ctrl", ctrl, 8'h00);
  endtask

  task automatic t_basic_lock;
    ref_per = 4; vco_per = 4; skip = 0;
    wr(8'hCD);
    check("R2 ctrl", ctrl, 8'hCD);
    wait_cyc(WIN + WIN/2);
    check("R5 not after one window", {7'd0, lock}, 8'd0);
    wait_cyc(WIN);
    check("R4 R5 lock at equal rate", {7'd0, lock}, 8'd1);
  endtask

  task automatic t_field_change;
    wr(8'hD1);  // ratio 0100, start still 1
    check("R7 lock cleared", {7'd0, lock}, 8'd0);
    vco_per = 2;  // matches new ratio
    wait_cyc(3*WIN);
    check("R7 R3 stays disarmed", {7'd0, lock}, 8'd0);
    wr(8'hD1);  // plain rewrite, no edge
    wait_cyc(3*WIN);
    check("R3 rewrite does not arm", {7'd0, lock}, 8'd0);
    wr(8'hD0);
    wr(8'hD1);
    wait_cyc(3*WIN);
    check("R9 twice ref rate locks", {7'd0, lock}, 8'd1);
    wr(8'hD1);
    check("R3 rewrite keeps lock", {7'd0, lock}, 8'd1);
    wr(8'hD0);
    check("R8 stop clears lock", {7'd0, lock}, 8'd0);
  endtask

  task automatic t_ratios;
    vco_per = 8;
    wr(8'hC8); wr(8'hC9);  // ratio 0010: half rate
    wait_cyc(3*WIN);
    check("R9 half ref rate locks", {7'd0, lock}, 8'd1);
    wr(8'h00); vco_per = 4;
    wr(8'h01);  // band 00 ratio 0000: equal
    wait_cyc(3*WIN);
    check("R9 band0 equal locks", {7'd0, lock}, 8'd1);
    wr(8'h00);
    vco_per = 8;
    wr(8'h01);
    wait_cyc(3*WIN);
    check("R4 mismatched rate no lock", {7'd0, lock}, 8'd0);
    wr(8'h00);
  endtask

  task automatic t_tolerance;
    ref_per = 4; vco_per = 4; skip = 2;
    wr(8'hCD);
    wait_cyc(3*WIN);
    check("R4 diff 2 within tolerance", {7'd0, lock}, 8'd1);
    skip = 3;
    wait_cyc(WIN*2 + 20);
    check("R6 diff 3 drops lock", {7'd0, lock}, 8'd0);
    skip = 0;
    wait_cyc(200);
    check("R5 no relock in one window", {7'd0, lock}, 8'd0);
    wait_cyc(3*WIN);
    check("R5 relock after good windows", {7'd0, lock}, 8'd1);
    wr(8'h00);
    skip = 3;
    wr(8'hCD);
    wait_cyc(3*WIN);
    check("R4 diff 3 never locks", {7'd0, lock}, 8'd0);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(2);
    t_basic_lock();
    t_field_change();
    t_ratios();
    t_tolerance();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule